// File: doc/BRIEF.md
# Packed Halving Add/Subtract Unit

This block is a lane-partitioned vector datapath for a SIMD execution pipe. It accepts two packed operand vectors and a small control word, and returns a packed result vector in which every element is the halved sum or halved difference of the matching operand elements. Each element is computed one bit wider than the lane, so the halved value never overflows. The dropped fraction bit is truncated toward minus infinity and never rounded.

The control word selects the lane width (8, 16 or 32 bits), whether lanes are signed two's complement or unsigned, add or subtract, and whether the full 128-bit vector or only its low 64 bits is processed. A request is taken when `in_valid` is high. Its result is registered and appears with `out_valid` one clock later. Register-file access, rounding, saturation and exception handling belong to the surrounding pipe.

Top module: `simd_halving_unit`

## Requirements
- R1: With `op_sub`=0, each result element equals floor((a+b)/2), computed at lane width plus one bit so that no sum overflows. For example, signed 8-bit 0x7F+0x7F gives 0x7F, and unsigned 0xFF+0xFF gives 0xFF.
- R2: With `op_sub`=1, each result element equals floor((a-b)/2), with `opb` subtracted from `opa`, truncated toward minus infinity and reduced to the low lane-width bits. For example, unsigned 8-bit 0x00-0xFF gives 0x80.
- R3: `size_sel` sets the lane width: 2'b00 selects 8 bits, 2'b01 selects 16 bits and 2'b10 selects 32 bits. Lane k occupies bits [k*W+W-1 : k*W].
- R4: `is_unsigned`=0 extends each lane as signed two's complement. `is_unsigned`=1 extends each lane with zeros.
- R5: `op_sub` selects the operation: 0 is halving add and 1 is halving subtract.
- R6: With `is_wide`=1, all 128 bits are processed. With `is_wide`=0, only bits [63:0] are processed, and result bits [127:64] are zero whatever the upper operand bits hold.
- R7: `size_sel`=2'b11 is reserved. It sets `out_illegal` and gives an all-zero result.
- R8: Carries and borrows never cross a lane boundary.
- R9: The result, `out_illegal` and `out_valid`=1 appear exactly one clock after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid` is 0 and `out_data` keeps its previous value.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_data` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; the operands and control are sampled when it is high |
| opa | input | 128 | First operand vector (minuend for subtract) |
| opb | input | 128 | Second operand vector |
| size_sel | input | 2 | Lane width: 00 is 8, 01 is 16, 10 is 32, 11 is reserved |
| is_unsigned | input | 1 | 1 for unsigned lanes, 0 for signed lanes |
| op_sub | input | 1 | 0 for halving add, 1 for halving subtract |
| is_wide | input | 1 | 1 for a 128-bit vector, 0 for a 64-bit vector |
| out_valid | output | 1 | The result is valid this cycle |
| out_data | output | 128 | Packed result vector |
| out_illegal | output | 1 | The request used the reserved size code |

## Verification
A wrong lane boundary or extension mode shows up at the ports on the very next clock as corrupted bits at lane edges. Such faults surface most clearly with all-ones and most-negative operands, where the extra precision bit decides the top result bit. A fault in the narrow-vector masking or in the handling of the reserved size code appears as nonzero upper or illegal-case result bits in that same cycle. A fault in the valid register or the hold logic shows as `out_valid` or `out_data` deviating one cycle after an idle cycle.

// File: rtl/simd_halve_pkg.sv
package simd_halve_pkg;

    typedef enum logic [1:0] {
        LANE_B8   = 2'b00,
        LANE_H16  = 2'b01,
        LANE_W32  = 2'b10,
        LANE_RSVD = 2'b11
    } lane_size_e;

    typedef struct packed {
        lane_size_e size;
        logic       is_unsigned;
        logic       op_sub;
        logic       is_wide;
    } hv_ctrl_t;

    function automatic logic size_is_legal(input lane_size_e s);
        return s != LANE_RSVD;
    endfunction

endpackage

// File: rtl/hv_lane.sv
module hv_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic              is_unsigned,
    input  logic              op_sub,
    output logic [LANE_W-1:0] res
);
    localparam int EXT_W = LANE_W + 1;

    logic [EXT_W-1:0] ea;
    logic [EXT_W-1:0] eb;
    logic [EXT_W-1:0] s;

    always_comb begin
        // one guard bit: sign copy for signed lanes, zero for unsigned lanes
        ea  = {(~is_unsigned) & a[LANE_W-1], a};
        eb  = {(~is_unsigned) & b[LANE_W-1], b};
        s   = op_sub ? (ea - eb) : (ea + eb);
        // drop the fraction bit: truncation toward minus infinity
        res = LANE_W'(s >> 1);
    end
endmodule

// File: rtl/hv_width_bank.sv
module hv_width_bank #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic             is_unsigned,
    input  logic             op_sub,
    output logic [VEC_W-1:0] res
);
    localparam int N_LANES = VEC_W / LANE_W;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        hv_lane #(.LANE_W(LANE_W)) u_lane (
            .a           (opa[g*LANE_W +: LANE_W]),
            .b           (opb[g*LANE_W +: LANE_W]),
            .is_unsigned (is_unsigned),
            .op_sub      (op_sub),
            .res         (res[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/hv_result_select.sv
module hv_result_select
    import simd_halve_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  hv_ctrl_t         ctrl,
    input  logic [VEC_W-1:0] res_b8,
    input  logic [VEC_W-1:0] res_h16,
    input  logic [VEC_W-1:0] res_w32,
    output logic [VEC_W-1:0] res,
    output logic             illegal
);
    localparam int HALF_W = VEC_W / 2;

    logic [VEC_W-1:0] picked;

    always_comb begin
        unique case (ctrl.size)
            LANE_B8:  picked = res_b8;
            LANE_H16: picked = res_h16;
            LANE_W32: picked = res_w32;
            default:  picked = '0;
        endcase
        illegal = !size_is_legal(ctrl.size);
        res     = picked;
        if (!ctrl.is_wide) res[VEC_W-1:HALF_W] = '0;
    end
endmodule

// File: rtl/simd_halving_unit.sv
module simd_halving_unit
    import simd_halve_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic [1:0]       size_sel,
    input  logic             is_unsigned,
    input  logic             op_sub,
    input  logic             is_wide,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data,
    output logic             out_illegal
);
    hv_ctrl_t         ctrl;
    logic [VEC_W-1:0] res_b8, res_h16, res_w32, res_next;
    logic             illegal_next;

    assign ctrl = '{size: lane_size_e'(size_sel), is_unsigned: is_unsigned,
                    op_sub: op_sub, is_wide: is_wide};

    hv_width_bank #(.VEC_W(VEC_W), .LANE_W(8)) u_bank8 (
        .opa(opa), .opb(opb), .is_unsigned(ctrl.is_unsigned),
        .op_sub(ctrl.op_sub), .res(res_b8));
    hv_width_bank #(.VEC_W(VEC_W), .LANE_W(16)) u_bank16 (
        .opa(opa), .opb(opb), .is_unsigned(ctrl.is_unsigned),
        .op_sub(ctrl.op_sub), .res(res_h16));
    hv_width_bank #(.VEC_W(VEC_W), .LANE_W(32)) u_bank32 (
        .opa(opa), .opb(opb), .is_unsigned(ctrl.is_unsigned),
        .op_sub(ctrl.op_sub), .res(res_w32));

    hv_result_select #(.VEC_W(VEC_W)) u_sel (
        .ctrl(ctrl), .res_b8(res_b8), .res_h16(res_h16), .res_w32(res_w32),
        .res(res_next), .illegal(illegal_next));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data    <= res_next;
                out_illegal <= illegal_next;
            end
        end
    end
endmodule

// File: rtl/simd_halving_chk.sv
module simd_halving_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       size_sel,
    input logic             is_wide,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_data,
    input logic             out_illegal
);
    localparam int HALF_W = VEC_W / 2;

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drops_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_data_held_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    p_narrow_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_wide) |=> (out_data[VEC_W-1:HALF_W] == '0));
    p_reserved_flag_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_illegal == (($past(size_sel)) == 2'b11)));
    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_data == '0));
endmodule

bind simd_halving_unit simd_halving_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
    .is_wide(is_wide), .out_valid(out_valid), .out_data(out_data),
    .out_illegal(out_illegal));

// File: tb/tb_simd_halving_unit.sv
module tb_simd_halving_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] opa, opb;
    logic [1:0]   size_sel;
    logic         is_unsigned, op_sub, is_wide;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_illegal;

    int n_checks = 0;
    int n_fail   = 0;

    always #4ns clk = ~clk;

    simd_halving_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .size_sel(size_sel), .is_unsigned(is_unsigned), .op_sub(op_sub),
        .is_wide(is_wide), .out_valid(out_valid), .out_data(out_data),
        .out_illegal(out_illegal));

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] sz, input logic u,
                                           input logic sub, input logic w);
        logic [127:0] r = '0;
        int lw, nl;
        longint mask, ea, eb, s;
        if (sz == 2'b11) return '0;
        lw   = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        nl   = (w ? 128 : 64) / lw;
        mask = (longint'(1) << lw) - 1;
        for (int i = 0; i < nl; i++) begin
            ea = longint'((a >> (i*lw)) & 128'(mask));
            eb = longint'((b >> (i*lw)) & 128'(mask));
            if (!u && ea[lw-1]) ea = ea - (longint'(1) << lw);
            if (!u && eb[lw-1]) eb = eb - (longint'(1) << lw);
            s = sub ? (ea - eb) : (ea + eb);
            s = s >>> 1;
            r = r | (128'(s & mask) << (i*lw));
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge (one register)
    task automatic send(input string tag, input logic [127:0] a, input logic [127:0] b,
                        input logic [1:0] sz, input logic u, input logic sub, input logic w);
        logic [127:0] exp;
        in_valid = 1'b1; opa = a; opb = b; size_sel = sz;
        is_unsigned = u; op_sub = sub; is_wide = w;
        exp = model(a, b, sz, u, sub, w);
        @(negedge clk);
        chk({tag, " valid"}, 128'(out_valid), 128'(1));
        chk({tag, " data"}, out_data, exp);
        chk({tag, " illegal"}, 128'(out_illegal), 128'(sz == 2'b11));
    endtask

    task automatic idle_check();
        logic [127:0] prev = out_data;
        in_valid = 1'b0;
        opa = {4{$urandom()}}; opb = {4{$urandom()}};
        @(negedge clk);
        chk("R9 idle valid low", 128'(out_valid), 128'(0));
        chk("R9 idle data held", out_data, prev);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8ns * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] ra, rb;
        rst = 1'b1; in_valid = 1'b0; opa = '0; opb = '0;
        size_sel = 2'b00; is_unsigned = 1'b0; op_sub = 1'b0; is_wide = 1'b1;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R10 reset valid", 128'(out_valid), 128'(0));
        chk("R10 reset data", out_data, '0);
        chk("R10 reset illegal", 128'(out_illegal), 128'(0));
        rst = 1'b0;

        // R1 / R4: extra precision bit, signed and unsigned
        send("R1 s8 max add", {16{8'h7F}}, {16{8'h7F}}, 2'b00, 1'b0, 1'b0, 1'b1);
        send("R1 s8 min add", {16{8'h80}}, {16{8'h80}}, 2'b00, 1'b0, 1'b0, 1'b1);
        send("R4 u8 ones add", {16{8'hFF}}, {16{8'hFF}}, 2'b00, 1'b1, 1'b0, 1'b1);
        send("R4 s8 ones add", {16{8'hFF}}, {16{8'h01}}, 2'b00, 1'b0, 1'b0, 1'b1);
        // R2 / R5: subtraction and floor truncation
        send("R2 s8 min-max", {16{8'h80}}, {16{8'h7F}}, 2'b00, 1'b0, 1'b1, 1'b1);
        send("R2 u8 zero-ones", {16{8'h00}}, {16{8'hFF}}, 2'b00, 1'b1, 1'b1, 1'b1);
        send("R5 s32 sub odd", {4{32'h0000_0003}}, {4{32'h0000_0006}}, 2'b10, 1'b0, 1'b1, 1'b1);
        // R8: carry must stay inside the lane
        send("R8 u16 carry", {8{16'hFFFF}}, {8{16'h0001}}, 2'b01, 1'b1, 1'b0, 1'b1);
        send("R8 u32 borrow", {4{32'h0}}, {4{32'h1}}, 2'b10, 1'b1, 1'b1, 1'b1);
        // R3: same data, each lane width
        for (int s = 0; s < 3; s++)
            send("R3 width sweep", 128'h8001_7FFF_00FF_FF00_1234_5678_9ABC_DEF0,
                 128'hFFFF_0001_8000_7F7F_0F0F_F0F0_5555_AAAA, 2'(s), 1'b0, 1'b0, 1'b1);
        // R6: narrow vector blanks upper half
        send("R6 narrow", {16{8'hC3}}, {16{8'h3C}}, 2'b01, 1'b1, 1'b0, 1'b0);
        // R7: reserved size code
        send("R7 reserved", {16{8'hAB}}, {16{8'hCD}}, 2'b11, 1'b0, 1'b0, 1'b1);
        idle_check();

        for (int i = 0; i < 3000; i++) begin
            ra = {$urandom(), $urandom(), $urandom(), $urandom()};
            rb = {$urandom(), $urandom(), $urandom(), $urandom()};
            send($urandom_range(1) ? "R1 random" : "R2 random", ra, rb,
                 2'($urandom_range(3)), 1'($urandom()), 1'($urandom()), 1'($urandom()));
            if ($urandom_range(15) == 0) idle_check();
        end

        // R10: reset in the middle of a run
        send("R10 pre-reset", {16{8'h55}}, {16{8'h11}}, 2'b00, 1'b1, 1'b0, 1'b1);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mid reset valid", 128'(out_valid), 128'(0));
        chk("R10 mid reset data", out_data, '0);
        finish_run();
    end
endmodule